// File: doc/BRIEF.md
# Four-Tap Digital Decision-Feedback Equalizer

This block cleans up post-cursor intersymbol interference on a stream of signed, digitized receiver samples arriving at one sample per clock. It keeps the last four symbol decisions, forms a weighted sum of them from four programmable tap weights, and removes that sum from the current sample. It then slices the corrected value to a binary symbol. The corrected value and the symbol are both registered and presented one cycle after the sample.

The taps cancel interference from symbols already decided, so the block does nothing about pre-cursor interference. When no other equalization is present in the link, the tap weights are set to the channel's unequalized pulse-response values at the first through fourth post-cursor positions. The newest decision feeds tap 1 for the very next sample, and no pipeline register sits on that path.

Top module: `decision_feedback_eq`

## Requirements
- R1: For each valid sample y, `out_eq` one cycle later equals y − (w1·d1 + w2·d2 + w3·d3 + w4·d4). Here d_i is +1 or −1, the decision made i valid samples earlier, and w_i is the signed tap weight.
- R2: `out_bit` is 1 (symbol +1) when the corrected value is zero or positive, and 0 (symbol −1) when it is negative. A corrected value of exactly zero gives 1.
- R3: `tap1_mag` is a 5-bit unsigned weight from 0 to 31 and always counts as positive.
- R4: `tap2_sm` is sign-magnitude. Bit 4 is the sign (1 means negative) and bits 3:0 are the magnitude.
- R5: `tap3_sm` and `tap4_sm` are sign-magnitude. Bit 3 is the sign (1 means negative) and bits 2:0 are the magnitude.
- R6: The decision history advances only on cycles with `in_vld` high. On a cycle with `in_vld` low, the history, `out_eq` and `out_bit` stay unchanged, so the next valid sample still sees the same four past decisions.
- R7: While `rst_n` is low at a clock edge, every history entry becomes +1, `out_vld` becomes 0, `out_eq` becomes 0 and `out_bit` becomes 1.
- R8: `out_vld` equals the value `in_vld` had one cycle earlier.
- R9: The corrected value is formed without wrap-around and clamped to the signed 8-bit range. With the default widths its extremes, −92 and +91, appear exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Marks `in_sample` as a real sample |
| in_sample | input | 6 | Two's complement receiver sample |
| tap1_mag | input | 5 | First post-cursor weight, unsigned |
| tap2_sm | input | 5 | Second post-cursor weight, sign-magnitude |
| tap3_sm | input | 4 | Third post-cursor weight, sign-magnitude |
| tap4_sm | input | 4 | Fourth post-cursor weight, sign-magnitude |
| out_vld | output | 1 | `in_vld` delayed by one cycle |
| out_bit | output | 1 | Decided symbol, 1 for +1 and 0 for −1 |
| out_eq | output | 8 | Corrected pre-slicer value, two's complement |

## Verification
The first runs use all taps at zero, which tests the slicer by itself, including a zero input. Next, tap 1 is set alone to full scale after reset, so the output shows both the +1 reset history and the one-sample feedback. Runs with the later taps set to negative weights show whether each sign bit sits at the stated position and inverts its contribution. Invalid cycles are inserted between valid samples to separate the history advancing on every clock from it advancing only on valid samples. A full-scale case reaches both extremes of the corrected value, and a long random stream with random weights is compared with a model built from the requirements.

// File: rtl/dfe_pkg.sv
// Package: shared constants and the symbol encoding for the equalizer.
// Assumes binary signalling: one decision bit per symbol.
package dfe_pkg;
    localparam int NUM_TAPS = 4;

    // Encoding of a decision: 1 stands for +1, 0 stands for -1.
    typedef enum logic {
        SYM_NEG = 1'b0,
        SYM_POS = 1'b1
    } sym_e;
endpackage

// File: rtl/dfe_tap_term.sv
// Module: one feedback tap contribution, weight times past symbol.
// Assumes the weight is sign-magnitude when SGN is 1 (sign on top) and an
// unsigned magnitude when SGN is 0. The output is a signed OUT_W value.
module dfe_tap_term #(
    parameter int MAG_W = 3,
    parameter int SGN   = 1,
    parameter int OUT_W = 12,
    localparam int IN_W = MAG_W + SGN
) (
    input  logic [IN_W-1:0]         weight,
    input  logic                    past_sym,
    output logic signed [OUT_W-1:0] term
);
    logic                    neg_weight;
    logic signed [OUT_W-1:0] mag_ext;

    // Pick the sign bit, or fix it to positive for an unsigned tap.
    if (SGN != 0) begin : g_signed
        assign neg_weight = weight[IN_W-1];
    end else begin : g_unsigned
        assign neg_weight = 1'b0;
    end

    assign mag_ext = OUT_W'({1'b0, weight[MAG_W-1:0]});

    // A -1 symbol and a negative weight each flip the contribution.
    always_comb begin
        if (neg_weight ^ (past_sym == dfe_pkg::SYM_NEG))
            term = -mag_ext;
        else
            term = mag_ext;
    end
endmodule

// File: rtl/dfe_fb_sum.sv
// Module: adds the per-tap contributions into one feedback value.
// Assumes OUT_W is wide enough for NUM_TAPS full-scale terms.
module dfe_fb_sum #(
    parameter int NUM_TAPS = 4,
    parameter int OUT_W    = 12
) (
    input  logic [NUM_TAPS-1:0][OUT_W-1:0] terms,
    output logic signed [OUT_W-1:0]        fb_sum
);
    // Plain combinational adder over all taps.
    always_comb begin
        fb_sum = '0;
        for (int i = 0; i < NUM_TAPS; i++)
            fb_sum = fb_sum + $signed(terms[i]);
    end
endmodule

// File: rtl/dfe_slicer.sv
// Module: subtracts the feedback from the sample, clamps to ACC_W bits and
// takes the sign as the decision. Purely combinational: it sits in the
// single-cycle loop together with tap 1.
module dfe_slicer #(
    parameter int SAMPLE_W = 6,
    parameter int ACC_W    = 8,
    parameter int WIDE_W   = 12
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [WIDE_W-1:0]   fb_sum,
    output logic signed [ACC_W-1:0]    eq_val,
    output logic                       sym
);
    localparam logic signed [WIDE_W-1:0] HI = WIDE_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] LO = -HI - WIDE_W'(1);

    logic signed [WIDE_W-1:0] sample_ext;
    logic signed [WIDE_W-1:0] diff;
    logic signed [WIDE_W-1:0] clamped;

    assign sample_ext = {{(WIDE_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
    assign diff       = sample_ext - fb_sum;

    // Saturate the difference into the output range.
    always_comb begin
        if (diff > HI)      clamped = HI;
        else if (diff < LO) clamped = LO;
        else                clamped = diff;
    end

    assign eq_val = ACC_W'(clamped);
    // Zero and positive map to +1.
    assign sym    = ~eq_val[ACC_W-1];
endmodule

// File: rtl/dfe_history.sv
// Module: shift register of past decisions; entry 0 is the newest.
// Advances only on valid samples; resets to all +1.
module dfe_history #(
    parameter int NUM_TAPS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                new_sym,
    output logic [NUM_TAPS-1:0] hist
);
    // Shift in the newest decision on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= {NUM_TAPS{dfe_pkg::SYM_POS}};
        else if (adv)
            hist <= {hist[NUM_TAPS-2:0], new_sym};
    end

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (hist[NUM_TAPS-1:1] == $past(hist[NUM_TAPS-2:0])) && (hist[0] == $past(new_sym)));

    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist));
endmodule

// File: rtl/decision_feedback_eq.sv
// Module: top of the four-tap decision-feedback equalizer.
// Assumes one sample per clock at most, qualified by in_vld. The tap-1
// feedback closes through the history register only, so a decision is
// used on the very next sample. Outputs are registered once.
module decision_feedback_eq #(
    parameter int SAMPLE_W = 6,
    parameter int ACC_W    = 8,
    parameter int TAP1_W   = 5,
    parameter int TAP2_M   = 4,
    parameter int TAP34_M  = 3,
    localparam int NT      = dfe_pkg::NUM_TAPS,
    localparam int WIDE_W  = ACC_W + 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [TAP1_W-1:0]         tap1_mag,
    input  logic [TAP2_M:0]           tap2_sm,
    input  logic [TAP34_M:0]          tap3_sm,
    input  logic [TAP34_M:0]          tap4_sm,
    output logic                      out_vld,
    output logic                      out_bit,
    output logic signed [ACC_W-1:0]   out_eq
);
    localparam int FB_MAX = (2 ** TAP1_W - 1) + (2 ** TAP2_M - 1) + 2 * (2 ** TAP34_M - 1);
    localparam int Z_HI_RAW = (2 ** (SAMPLE_W - 1) - 1) + FB_MAX;
    localparam int Z_LO_RAW = -(2 ** (SAMPLE_W - 1)) - FB_MAX;
    localparam int A_HI = 2 ** (ACC_W - 1) - 1;
    localparam int A_LO = -(2 ** (ACC_W - 1));
    localparam int Z_HI = (Z_HI_RAW > A_HI) ? A_HI : Z_HI_RAW;
    localparam int Z_LO = (Z_LO_RAW < A_LO) ? A_LO : Z_LO_RAW;

    // Magnitude width of each tap.
    function automatic int mag_w(input int idx);
        case (idx)
            0:       return TAP1_W;
            1:       return TAP2_M;
            default: return TAP34_M;
        endcase
    endfunction

    logic [NT-1:0]             hist;
    logic [NT-1:0][WIDE_W-1:0] terms;
    logic signed [WIDE_W-1:0]  fb_sum;
    logic signed [ACC_W-1:0]   eq_val;
    logic                      sym;

    for (genvar gi = 0; gi < NT; gi++) begin : g_tap
        localparam int MW = mag_w(gi);
        localparam int SG = (gi != 0) ? 1 : 0;
        logic [MW+SG-1:0]         wt;
        logic signed [WIDE_W-1:0] term_g;

        if (gi == 0) begin : g_w1
            assign wt = tap1_mag;
        end else if (gi == 1) begin : g_w2
            assign wt = tap2_sm;
        end else if (gi == 2) begin : g_w3
            assign wt = tap3_sm;
        end else begin : g_w4
            assign wt = tap4_sm;
        end

        dfe_tap_term #(.MAG_W(MW), .SGN(SG), .OUT_W(WIDE_W)) u_term (
            .weight   (wt),
            .past_sym (hist[gi]),
            .term     (term_g)
        );
        assign terms[gi] = term_g;
    end

    dfe_fb_sum #(.NUM_TAPS(NT), .OUT_W(WIDE_W)) u_sum (
        .terms  (terms),
        .fb_sum (fb_sum)
    );

    dfe_slicer #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .WIDE_W(WIDE_W)) u_slice (
        .sample (in_sample),
        .fb_sum (fb_sum),
        .eq_val (eq_val),
        .sym    (sym)
    );

    dfe_history #(.NUM_TAPS(NT)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_vld),
        .new_sym (sym),
        .hist    (hist)
    );

    // Output registers: capture the result on valid samples, flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_bit <= dfe_pkg::SYM_POS;
            out_eq  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_bit <= sym;
                out_eq  <= eq_val;
            end
        end
    end

    assert_vld_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    assert_vld_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    assert_zero_is_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_bit == (out_eq >= 0)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((int'(out_eq) <= Z_HI) && (int'(out_eq) >= Z_LO)));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_eq) && $stable(out_bit)));
endmodule

// File: tb/decision_feedback_eq_tb_top.sv
module decision_feedback_eq_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic signed [5:0] in_sample = '0;
    logic [4:0]        tap1_mag = '0;
    logic [4:0]        tap2_sm = '0;
    logic [3:0]        tap3_sm = '0;
    logic [3:0]        tap4_sm = '0;
    logic              out_vld;
    logic              out_bit;
    logic signed [7:0] out_eq;

    int checks = 0;
    int errors = 0;

    // Model state, built from the requirements.
    bit mh [4];
    int last_eq;
    bit last_bit;

    always #5 clk = ~clk;

    decision_feedback_eq dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(in_sample),
        .tap1_mag(tap1_mag), .tap2_sm(tap2_sm), .tap3_sm(tap3_sm), .tap4_sm(tap4_sm),
        .out_vld(out_vld), .out_bit(out_bit), .out_eq(out_eq)
    );

    function automatic int wval(input int i);
        case (i)
            0: return int'(tap1_mag);
            1: return tap2_sm[4] ? -int'(tap2_sm[3:0]) : int'(tap2_sm[3:0]);
            2: return tap3_sm[3] ? -int'(tap3_sm[2:0]) : int'(tap3_sm[2:0]);
            default: return tap4_sm[3] ? -int'(tap4_sm[2:0]) : int'(tap4_sm[2:0]);
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    // Reset the design and the model, then check the reset outputs (R7).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        foreach (mh[i]) mh[i] = 1'b1;
        last_eq = 0; last_bit = 1'b1;
        check("R7", int'(out_vld), 0, "out_vld");
        check("R7", int'(out_eq), 0, "out_eq");
        check("R7", int'(out_bit), 1, "out_bit");
    endtask

    // Drive one cycle and check the registered result one cycle later.
    task automatic step(input int y, input bit vld, input string req);
        int fb, z;
        bit d;
        in_sample = 6'(y);
        in_vld = vld;
        fb = 0;
        for (int i = 0; i < 4; i++) fb += wval(i) * (mh[i] ? 1 : -1);
        z = y - fb;
        if (z > 127) z = 127;
        if (z < -128) z = -128;
        d = (z >= 0);
        @(negedge clk);
        check("R8", int'(out_vld), int'(vld), "out_vld");
        if (vld) begin
            check(req, int'(out_eq), z, "out_eq");
            check(req, int'(out_bit), int'(d), "out_bit");
            for (int i = 3; i > 0; i--) mh[i] = mh[i-1];
            mh[0] = d;
            last_eq = z; last_bit = d;
        end else begin
            check("R6", int'(out_eq), last_eq, "out_eq held");
            check("R6", int'(out_bit), int'(last_bit), "out_bit held");
        end
    endtask

    task automatic set_taps(input int t1, input int t2, input int t3, input int t4);
        tap1_mag = 5'(t1); tap2_sm = 5'(t2); tap3_sm = 4'(t3); tap4_sm = 4'(t4);
    endtask

    // Slicer alone, including a zero input (R2).
    task automatic t_slicer();
        do_reset();
        set_taps(0, 0, 0, 0);
        step(5, 1, "R2");
        step(-3, 1, "R2");
        step(0, 1, "R2");
        check("R2", int'(out_bit), 1, "zero slices to +1");
        step(-32, 1, "R2");
        step(31, 1, "R1");
    endtask

    // Tap 1 alone at full scale: reset history is +1, feedback in one sample (R3, R7).
    task automatic t_tap1();
        do_reset();
        set_taps(31, 0, 0, 0);
        step(0, 1, "R3");
        check("R7", int'(out_eq), -31, "first sample sees +1 history");
        step(0, 1, "R3");
        check("R3", int'(out_eq), 31, "tap1 after a -1 decision");
        step(10, 1, "R1");
    endtask

    // Negative later taps: sign bit positions (R4, R5).
    task automatic t_signed();
        do_reset();
        set_taps(0, 5'b1_0101, 4'b1_011, 4'b0_010);
        step(0, 1, "R4");
        check("R4", int'(out_eq), 5 + 3 - 2, "signed taps with +1 history");
        set_taps(0, 5'b0_0111, 4'b0_000, 4'b1_111);
        step(-4, 1, "R5");
        step(2, 1, "R5");
        step(-1, 1, "R4");
        step(6, 1, "R5");
    endtask

    // Invalid cycles between samples must not move the history (R6).
    task automatic t_gaps();
        do_reset();
        set_taps(9, 5'b0_0011, 4'b1_010, 4'b0_001);
        step(-20, 1, "R6");
        step(25, 0, "R6");
        step(25, 0, "R6");
        step(4, 1, "R6");
        step(-7, 0, "R6");
        step(-2, 1, "R6");
        step(0, 1, "R6");
    endtask

    // Both extremes of the corrected value (R9).
    task automatic t_extremes();
        do_reset();
        set_taps(31, 5'b0_1111, 4'b0_111, 4'b0_111);
        step(-32, 1, "R9");
        check("R9", int'(out_eq), -92, "lowest corrected value");
        set_taps(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(-1, 1, "R9");
        set_taps(31, 5'b0_1111, 4'b0_111, 4'b0_111);
        step(31, 1, "R9");
        check("R9", int'(out_eq), 91, "highest corrected value");
    endtask

    // Long random stream against the model (R1).
    task automatic t_random();
        do_reset();
        set_taps(int'($urandom_range(31)), int'($urandom_range(31)),
                 int'($urandom_range(15)), int'($urandom_range(15)));
        for (int n = 0; n < 200; n++) begin
            step(int'($urandom_range(63)) - 32, ($urandom_range(3) != 0), "R1");
            if ((n % 50) == 49)
                set_taps(int'($urandom_range(31)), int'($urandom_range(31)),
                         int'($urandom_range(15)), int'($urandom_range(15)));
        end
    endtask

    initial begin
        t_slicer();
        t_tap1();
        t_signed();
        t_gaps();
        t_extremes();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule